// File: doc/BRIEF.md
# Dual-Clock 8-bit Real-Time Counter with Bus-Side Synchronizer

This block is an 8-bit counter that runs on a slow, free-running oscillator clock. The processor reaches it from its own faster bus clock. No multi-bit value crosses between the two domains unless a toggle handshake shows that the value is stable. The bus side reads the count from a shadow register. That register is reloaded after every rising edge of the timer clock, so a read always returns a slightly old count.

The compare value and the control byte are written on the bus side. Each goes into a holding register with its own busy flag, and the flag stays up until the timer domain has taken the value. A write that arrives while its busy flag is set is dropped and recorded in a sticky error bit.

Overflow and compare-match events are raised in the timer domain and carried to the bus domain as flags. The timer domain also drives a compare output pin directly. While the core is asleep, the timer domain asserts a wake request one timer cycle after an event.

Top module: `async_rtc_timer`

## Requirements
- R1: While reset is active and just after it is released, every output reads zero: cnt_rd, both busy flags, wr_err, ovf_flag, cmp_flag, cmp_pin and wake_req.
- R2: Control bit 0 (run) controls the counter. When it is 1, the timer-domain counter rises by one on each timer-clock edge and wraps from 255 to 0. When it is 0, the counter holds its value.
- R3: cnt_rd is a bus-domain copy of the counter. It changes only after a timer-clock edge. While the counter runs, each new value is the previous value plus one, modulo 256, or 0 after the compare value when clear-on-match is set.
- R4: wr_sel selects the target of a write: 0 is the compare register and 1 is the control register. An accepted write raises that register's busy flag on the next bus cycle. The flag falls once the timer domain has taken the value.
- R5: A write to a register whose busy flag is set is dropped, so the earlier value stays in force. The dropped write sets wr_err, which stays set until flag_clr bit 2 is pulsed.
- R6: ovf_flag sets when the counter wraps from 255 to 0, about three bus cycles after that timer edge. In the bus cycle where ovf_flag first reads 1, cnt_rd reads 0. A pulse on flag_clr bit 0 clears ovf_flag.
- R7: cmp_flag sets after the timer edge on which a running counter equals the compare value. In the bus cycle where cmp_flag first reads 1, cnt_rd reads the compare value plus one. A pulse on flag_clr bit 1 clears cmp_flag.
- R8: When control bit 1 (clear-on-match) is 1, the counter steps from the compare value to 0 instead of counting up.
- R9: cmp_pin is a flop in the timer domain. When control bit 2 is 0, the pin toggles on each compare match. When control bit 2 is 1, a match sets the pin and an overflow clears it.
- R10: While sleep_req is high, wake_req rises on the timer edge after an event edge. At that moment cnt_rd still shows the event value plus one, and a few bus cycles later it shows the event value plus two. wake_req stays low while sleep_req is low and falls after sleep_req drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Processor bus clock |
| tmr_clk | input | 1 | Slow asynchronous counter clock |
| rst | input | 1 | Active-high reset; its release is synchronized into each domain |
| wr_en | input | 1 | Write strobe, one bus cycle |
| wr_sel | input | 1 | Write target: 0 compare, 1 control |
| wr_data | input | CNT_W | Write value |
| flag_clr | input | 3 | Clear pulses: bit0 ovf_flag, bit1 cmp_flag, bit2 wr_err |
| sleep_req | input | 1 | Core is asleep; enables wake requests |
| cnt_rd | output | CNT_W | Bus-domain copy of the count |
| cmp_busy | output | 1 | Compare write still in transfer |
| ctl_busy | output | 1 | Control write still in transfer |
| wr_err | output | 1 | Sticky: a write was dropped while busy |
| ovf_flag | output | 1 | Overflow event flag, bus domain |
| cmp_flag | output | 1 | Compare-match event flag, bus domain |
| cmp_pin | output | 1 | Compare output, timer domain |
| wake_req | output | 1 | Wake request, timer domain |

## Verification
A wrong transfer state shows at the ports within a few bus cycles. A busy flag either never falls, or the value that takes effect is not the last accepted write. A match at the wrong count is visible at the next flag rise, where cnt_rd differs from compare plus one. The flag and shadow-copy paths must stay aligned: if one synchronizer chain has the wrong length, cnt_rd is off by one in the cycle where a flag rises. A wrong wake delay shows as a stale or already-advanced count at the moment wake_req rises.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int WR_CMP   = 0;
   localparam int WR_CTL   = 1;
   localparam int NUM_WR   = 2;
   localparam int CTL_RUN  = 0;
   localparam int CTL_CLR  = 1;
   localparam int CTL_PSET = 2;
   localparam int EV_UPD   = 0;
   localparam int EV_CMP   = 1;
   localparam int EV_OVF   = 2;
   localparam int NUM_EV   = 3;
   localparam int CLR_OVF  = 0;
   localparam int CLR_CMP  = 1;
   localparam int CLR_ERR  = 2;
endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_in,
   output logic rst_out
);
   logic [STAGES-1:0] q;

   // Assertion is immediate; release walks through STAGES flops.
   always_ff @(posedge clk or posedge rst_in) begin
      if (rst_in) q <= '1;
      else        q <= {q[STAGES-2:0], 1'b0};
   end

   assign rst_out = q[STAGES-1];
endmodule

// File: rtl/rtc_bit_sync.sv
module rtc_bit_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rtc_wr_chan.sv
module rtc_wr_chan #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         bus_clk,
   input  logic         bus_rst,
   input  logic         tmr_clk,
   input  logic         tmr_rst,
   input  logic         wr_req,
   input  logic [W-1:0] wr_val,
   output logic         busy,
   output logic         dropped,
   output logic [W-1:0] tmr_val
);
   logic         req_tgl, ack_sync;
   logic [W-1:0] hold_q;
   logic         req_sync, ack_tgl;

   // Bus side: the holding register stays frozen while a transfer is open.
   always_ff @(posedge bus_clk) begin
      if (bus_rst) begin
         req_tgl <= 1'b0;
         hold_q  <= '0;
      end else if (wr_req && !busy) begin
         hold_q  <= wr_val;
         req_tgl <= ~req_tgl;
      end
   end

   assign busy    = req_tgl ^ ack_sync;
   assign dropped = wr_req & busy;

   rtc_bit_sync #(.STAGES(STAGES)) u_req_s (
      .clk(tmr_clk), .rst(tmr_rst), .d(req_tgl), .q(req_sync));

   // Timer side: take the stable holding value and return the toggle.
   always_ff @(posedge tmr_clk) begin
      if (tmr_rst) begin
         ack_tgl <= 1'b0;
         tmr_val <= '0;
      end else begin
         if (req_sync != ack_tgl) tmr_val <= hold_q;
         ack_tgl <= req_sync;
      end
   end

   rtc_bit_sync #(.STAGES(STAGES)) u_ack_s (
      .clk(bus_clk), .rst(bus_rst), .d(ack_tgl), .q(ack_sync));
endmodule

// File: rtl/rtc_evt_xfer.sv
module rtc_evt_xfer #(
   parameter int STAGES = 2
) (
   input  logic bus_clk,
   input  logic bus_rst,
   input  logic tgl_in,
   output logic pulse
);
   logic s_q, last_q;

   rtc_bit_sync #(.STAGES(STAGES)) u_s (
      .clk(bus_clk), .rst(bus_rst), .d(tgl_in), .q(s_q));

   always_ff @(posedge bus_clk) begin
      if (bus_rst) last_q <= 1'b0;
      else         last_q <= s_q;
   end

   assign pulse = s_q ^ last_q;
endmodule

// File: rtl/rtc_core.sv
module rtc_core #(
   parameter int W      = 8,
   parameter bit CTC_EN = 1'b1
) (
   input  logic                       tmr_clk,
   input  logic                       tmr_rst,
   input  logic [W-1:0]               ctl,
   input  logic [W-1:0]               cmp,
   input  logic                       sleep_t,
   output logic [W-1:0]               cnt,
   output logic [rtc_pkg::NUM_EV-1:0] ev_tgl,
   output logic                       pin,
   output logic                       wake
);
   import rtc_pkg::*;

   logic run, clr_mode, match, wrap, evt_d;

   generate
      if (CTC_EN) begin : g_clr
         assign clr_mode = ctl[CTL_CLR];
      end else begin : g_noclr
         assign clr_mode = 1'b0;
      end
   endgenerate

   assign run   = ctl[CTL_RUN];
   assign match = run && (cnt == cmp);
   assign wrap  = run && (cnt == '1) && !(clr_mode && match);

   always_ff @(posedge tmr_clk) begin
      if (tmr_rst) begin
         cnt    <= '0;
         ev_tgl <= '0;
         pin    <= 1'b0;
         evt_d  <= 1'b0;
         wake   <= 1'b0;
      end else begin
         if (clr_mode && match) cnt <= '0;
         else if (run)          cnt <= W'(cnt + 1'b1);
         ev_tgl[EV_UPD] <= ~ev_tgl[EV_UPD];
         ev_tgl[EV_CMP] <= ev_tgl[EV_CMP] ^ match;
         ev_tgl[EV_OVF] <= ev_tgl[EV_OVF] ^ wrap;
         if (ctl[CTL_PSET]) begin
            if (match)     pin <= 1'b1;
            else if (wrap) pin <= 1'b0;
         end else if (match) begin
            pin <= ~pin;
         end
         evt_d <= match | wrap;
         wake  <= sleep_t ? (wake | evt_d) : 1'b0;
      end
   end
endmodule

// File: rtl/async_rtc_timer.sv
module async_rtc_timer #(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit CTC_EN      = 1'b1
) (
   input  logic             bus_clk,
   input  logic             tmr_clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [2:0]       flag_clr,
   input  logic             sleep_req,
   output logic [CNT_W-1:0] cnt_rd,
   output logic             cmp_busy,
   output logic             ctl_busy,
   output logic             wr_err,
   output logic             ovf_flag,
   output logic             cmp_flag,
   output logic             cmp_pin,
   output logic             wake_req
);
   import rtc_pkg::*;

   generate
      if (CNT_W < 3) begin : g_bad_w
         $error("CNT_W must hold the three control bits");
      end
      if (SYNC_STAGES < 2) begin : g_bad_s
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic                rst_b, rst_t, sleep_t;
   logic [NUM_WR-1:0]   busy_v, drop_v;
   logic [CNT_W-1:0]    xfer_val [NUM_WR];
   logic [CNT_W-1:0]    core_cnt;
   logic [NUM_EV-1:0]   ev_tgl, ev_pls;

   rtc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_b (
      .clk(bus_clk), .rst_in(rst), .rst_out(rst_b));
   rtc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_t (
      .clk(tmr_clk), .rst_in(rst), .rst_out(rst_t));

   genvar gi;
   generate
      for (gi = 0; gi < NUM_WR; gi++) begin : g_wr
         rtc_wr_chan #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_chan (
            .bus_clk (bus_clk),
            .bus_rst (rst_b),
            .tmr_clk (tmr_clk),
            .tmr_rst (rst_t),
            .wr_req  (wr_en && (wr_sel == 1'(gi))),
            .wr_val  (wr_data),
            .busy    (busy_v[gi]),
            .dropped (drop_v[gi]),
            .tmr_val (xfer_val[gi]));
      end
   endgenerate

   rtc_bit_sync #(.STAGES(SYNC_STAGES)) u_sleep_s (
      .clk(tmr_clk), .rst(rst_t), .d(sleep_req), .q(sleep_t));

   rtc_core #(.W(CNT_W), .CTC_EN(CTC_EN)) u_core (
      .tmr_clk (tmr_clk),
      .tmr_rst (rst_t),
      .ctl     (xfer_val[WR_CTL]),
      .cmp     (xfer_val[WR_CMP]),
      .sleep_t (sleep_t),
      .cnt     (core_cnt),
      .ev_tgl  (ev_tgl),
      .pin     (cmp_pin),
      .wake    (wake_req));

   generate
      for (gi = 0; gi < NUM_EV; gi++) begin : g_ev
         rtc_evt_xfer #(.STAGES(SYNC_STAGES)) u_x (
            .bus_clk(bus_clk), .bus_rst(rst_b),
            .tgl_in(ev_tgl[gi]), .pulse(ev_pls[gi]));
      end
   endgenerate

   // core_cnt last changed on the same timer edge as the refresh toggle, so
   // it has been stable for SYNC_STAGES bus cycles when the pulse arrives.
   always_ff @(posedge bus_clk) begin
      if (rst_b) begin
         cnt_rd   <= '0;
         ovf_flag <= 1'b0;
         cmp_flag <= 1'b0;
         wr_err   <= 1'b0;
      end else begin
         if (ev_pls[EV_UPD]) cnt_rd <= core_cnt;
         if (ev_pls[EV_OVF])          ovf_flag <= 1'b1;
         else if (flag_clr[CLR_OVF])  ovf_flag <= 1'b0;
         if (ev_pls[EV_CMP])          cmp_flag <= 1'b1;
         else if (flag_clr[CLR_CMP])  cmp_flag <= 1'b0;
         if (|drop_v)                 wr_err   <= 1'b1;
         else if (flag_clr[CLR_ERR])  wr_err   <= 1'b0;
      end
   end

   assign cmp_busy = busy_v[WR_CMP];
   assign ctl_busy = busy_v[WR_CTL];
endmodule

// File: rtl/rtc_chk.sv
module rtc_chk #(
   parameter int W      = 8,
   parameter bit CTC_EN = 1'b1
) (
   input logic         bus_clk,
   input logic         tmr_clk,
   input logic         rst,
   input logic         rst_b,
   input logic         rst_t,
   input logic         wr_en,
   input logic         wr_sel,
   input logic [2:0]   flag_clr,
   input logic         cmp_busy,
   input logic         ctl_busy,
   input logic         wr_err,
   input logic         ovf_flag,
   input logic         ovf_pls,
   input logic         upd_pls,
   input logic [W-1:0] cnt_rd,
   input logic [W-1:0] cnt_t,
   input logic [W-1:0] ctl_t,
   input logic [W-1:0] cmp_t,
   input logic         cmp_pin
);
   logic run_t, clr_t, hit_t, top_t;
   assign run_t = ctl_t[0];
   assign clr_t = CTC_EN && ctl_t[1];
   assign hit_t = run_t && (cnt_t == cmp_t);
   assign top_t = run_t && (cnt_t == '1);

   // R4
   cmp_accept_chk: assert property (@(posedge bus_clk) disable iff (rst || rst_b)
      (wr_en && !wr_sel && !cmp_busy) |=> cmp_busy);
   // R4
   ctl_accept_chk: assert property (@(posedge bus_clk) disable iff (rst || rst_b)
      (wr_en && wr_sel && !ctl_busy) |=> ctl_busy);
   // R5
   cmp_drop_chk: assert property (@(posedge bus_clk) disable iff (rst || rst_b)
      (wr_en && !wr_sel && cmp_busy) |=> wr_err);
   // R5
   ctl_drop_chk: assert property (@(posedge bus_clk) disable iff (rst || rst_b)
      (wr_en && wr_sel && ctl_busy) |=> wr_err);
   // R6
   ovf_clear_chk: assert property (@(posedge bus_clk) disable iff (rst || rst_b)
      (flag_clr[0] && !ovf_pls) |=> !ovf_flag);
   // R3
   copy_hold_chk: assert property (@(posedge bus_clk) disable iff (rst || rst_b)
      !upd_pls |=> $stable(cnt_rd));
   // R2
   count_step_chk: assert property (@(posedge tmr_clk) disable iff (rst || rst_t)
      (run_t && !(clr_t && hit_t)) |=> (cnt_t == W'($past(cnt_t) + 1'b1)));
   // R2
   count_hold_chk: assert property (@(posedge tmr_clk) disable iff (rst || rst_t)
      !run_t |=> $stable(cnt_t));
   // R8
   clr_match_chk: assert property (@(posedge tmr_clk) disable iff (rst || rst_t)
      (clr_t && hit_t) |=> (cnt_t == '0));
   // R9
   pin_quiet_chk: assert property (@(posedge tmr_clk) disable iff (rst || rst_t)
      !(hit_t || top_t) |=> $stable(cmp_pin));
endmodule

bind async_rtc_timer rtc_chk #(.W(CNT_W), .CTC_EN(CTC_EN)) u_chk (
   .bus_clk  (bus_clk),
   .tmr_clk  (tmr_clk),
   .rst      (rst),
   .rst_b    (rst_b),
   .rst_t    (rst_t),
   .wr_en    (wr_en),
   .wr_sel   (wr_sel),
   .flag_clr (flag_clr),
   .cmp_busy (cmp_busy),
   .ctl_busy (ctl_busy),
   .wr_err   (wr_err),
   .ovf_flag (ovf_flag),
   .ovf_pls  (ev_pls[2]),
   .upd_pls  (ev_pls[0]),
   .cnt_rd   (cnt_rd),
   .cnt_t    (core_cnt),
   .ctl_t    (xfer_val[1]),
   .cmp_t    (xfer_val[0]),
   .cmp_pin  (cmp_pin));

// File: tb/sim_async_rtc_timer.sv
module sim_async_rtc_timer;
   logic       bus_clk = 1'b0;
   logic       tmr_clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [7:0] wr_data = '0;
   logic [2:0] flag_clr = '0;
   logic       sleep_req = 1'b0;
   logic [7:0] cnt_rd;
   logic       cmp_busy, ctl_busy, wr_err, ovf_flag, cmp_flag, cmp_pin, wake_req;

   always #4  bus_clk = ~bus_clk;   // 125 MHz
   always #41.5 tmr_clk = ~tmr_clk; // slow, unrelated

   async_rtc_timer u0 (
      .bus_clk, .tmr_clk, .rst, .wr_en, .wr_sel, .wr_data, .flag_clr,
      .sleep_req, .cnt_rd, .cmp_busy, .ctl_busy, .wr_err, .ovf_flag,
      .cmp_flag, .cmp_pin, .wake_req);

   typedef struct {
      string tag;
      int    act;
      int    exp;
   } item_t;
   item_t sb_q [$];
   int n_vec = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   // driver side: push one expected/actual pair
   task automatic chk(input string tag, input int act, input int exp);
      item_t it;
      it.tag = tag; it.act = act; it.exp = exp;
      sb_q.push_back(it);
   endtask

   // scoreboard monitor: pops and compares
   always @(posedge bus_clk) begin
      while (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         n_vec++;
         if (it.act != it.exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", it.tag, it.act, it.exp);
         end
      end
   end

   // R3 stepping monitor on the visible copy
   bit mon_on = 1'b0;
   bit mon_clr = 1'b0;
   int mon_top = 5;
   int last_rd = 0;
   always @(negedge bus_clk) begin
      if (mon_on && (int'(cnt_rd) != last_rd))
         chk("R3 copy step", int'(cnt_rd),
             (mon_clr && last_rd == mon_top) ? 0 : (last_rd + 1) % 256);
      last_rd = int'(cnt_rd);
   end

   always @(posedge bus_clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   task automatic tick(input int n);
      for (int k = 0; k < n; k++) @(negedge bus_clk);
   endtask

   task automatic wr(input bit sel, input int val);
      @(negedge bus_clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = 8'(val);
      @(negedge bus_clk);
      wr_en = 1'b0;
   endtask

   task automatic clr(input int idx);
      @(negedge bus_clk);
      flag_clr = 3'(1 << idx);
      @(negedge bus_clk);
      flag_clr = '0;
   endtask

   // 0 cmp_busy low, 1 ctl_busy low, 2 cmp_flag high, 3 ovf_flag high, 4 wake high
   task automatic wait_for(input int which, input int limit);
      for (int k = 0; k < limit; k++) begin
         bit hit;
         case (which)
            0: hit = !cmp_busy;
            1: hit = !ctl_busy;
            2: hit = cmp_flag;
            3: hit = ovf_flag;
            default: hit = wake_req;
         endcase
         if (hit) return;
         @(negedge bus_clk);
      end
   endtask

   initial begin
      int v, p0, mx;
      tick(20);
      @(negedge bus_clk) rst = 1'b0;
      tick(6);
      // R1 reset state
      chk("R1 cnt_rd", cnt_rd, 0);
      chk("R1 busy", {cmp_busy, ctl_busy}, 0);
      chk("R1 flags", {wr_err, ovf_flag, cmp_flag}, 0);
      chk("R1 pin/wake", {cmp_pin, wake_req}, 0);
      tick(40);

      // R4 / R5: compare write, then a dropped one
      wr(1'b0, 5);
      chk("R4 cmp busy after write", cmp_busy, 1);
      wr(1'b0, 9);
      chk("R5 sticky error", wr_err, 1);
      wait_for(0, 400);
      chk("R4 cmp busy clears", cmp_busy, 0);
      clr(2);
      chk("R5 error cleared", wr_err, 0);

      // R2 start counting
      wr(1'b1, 1);
      chk("R4 ctl busy after write", ctl_busy, 1);
      wait_for(1, 400);
      chk("R4 ctl busy clears", ctl_busy, 0);
      mon_on = 1'b1;

      // R7: first match must be at 5, not the dropped 9 (R5)
      wait_for(2, 5000);
      chk("R7 cnt_rd at cmp flag", cnt_rd, 6);
      clr(1);
      chk("R7 cmp flag cleared", cmp_flag, 0);

      // R6 overflow
      clr(0);
      wait_for(3, 5000);
      chk("R6 cnt_rd at ovf flag", cnt_rd, 0);
      chk("R10 no wake while awake", wake_req, 0);
      clr(0);
      chk("R6 ovf flag cleared", ovf_flag, 0);

      // R2 hold when stopped
      mon_on = 1'b0;
      wr(1'b1, 0);
      wait_for(1, 400);
      tick(40);
      v = int'(cnt_rd);
      tick(150);
      chk("R2 count holds when stopped", cnt_rd, v);

      // R8 clear-on-match, R9 toggle mode
      mon_clr = 1'b1; mon_top = 5;
      wr(1'b1, 3);
      wait_for(1, 400);
      mon_on = 1'b1;
      clr(1);
      wait_for(2, 5000);
      clr(1);
      p0 = int'(cmp_pin);
      wait_for(2, 5000);
      chk("R9 pin toggles per match", cmp_pin, p0 ^ 1);
      mx = 0;
      for (int k = 0; k < 300; k++) begin
         @(negedge bus_clk);
         if (int'(cnt_rd) > mx) mx = int'(cnt_rd);
      end
      chk("R8 count never passes compare", mx, 5);

      // R9 set/clear mode
      mon_on = 1'b0;
      wr(1'b1, 5);
      wait_for(1, 400);
      mon_clr = 1'b0;
      tick(20);
      mon_on = 1'b1;
      clr(1);
      wait_for(2, 5000);
      chk("R9 pin high on match", cmp_pin, 1);
      clr(0);
      wait_for(3, 5000);
      chk("R9 pin low on overflow", cmp_pin, 0);

      // R10 wake
      @(negedge bus_clk) sleep_req = 1'b1;
      clr(1);
      wait_for(2, 5000);
      chk("R10 wake not yet at flag", wake_req, 0);
      wait_for(4, 200);
      chk("R10 wake raised", wake_req, 1);
      chk("R10 stale copy at wake", cnt_rd, 6);
      tick(6);
      chk("R10 copy advanced after wake", cnt_rd, 7);
      @(negedge bus_clk) sleep_req = 1'b0;
      tick(300);
      chk("R10 wake drops after sleep ends", wake_req, 0);

      tick(4);
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule